// File: doc/BRIEF.md
# Cascadable Segment RAM Byte Loader

This block sits behind a serial-bus decoder in a segment display driver. It takes whole data bytes and spreads their bits over a small display memory of 80 columns by 4 rows. A column pointer selects where each byte lands. A device-select counter decides whether this device stores the byte at all. The drive mode sets how many rows one column uses (1, 2, 3 or 4). A byte is laid out most significant bit first: down the rows of a column, then on to the next column.

Several identical devices can share one byte stream. Each device has its own 3-bit strapped address, and a device stores only the bits whose counter value equals that address. When the pointer runs past the last column it wraps to column 0 and the counter advances. The stream therefore moves on to the next device, even when the wrap falls inside a single byte. Bytes that this device skips still move the pointer.

If a bus transfer is cut short, the pointer is treated as unknown. Data bytes are then ignored until the next pointer load. A readback port returns the four row bits of any column.

Top module: `seg_ram_loader`

## Requirements
- R1: After reset the pointer is not valid, the device-select counter is 0, every RAM cell is 0, `wr_pulse` is 0 and `rd_data` is 0.
- R2: A pointer load with `ptr_ld_col` below 80 sets the pointer to that column and marks it valid. A load with a value of 80 or more leaves the pointer not valid.
- R3: `drive_mode` encoding: 00 means 1 row per column, 01 means 2 rows, 10 means 3 rows, 11 means 4 rows. After each accepted byte the pointer advances by 8, 4, 3 or 2 columns respectively.
- R4: Byte bit 7-k (k = 0..7) goes to column pointer + k/R, row k mod R, where R is the row count. With R = 3, row 2 of the third column keeps its old value.
- R5: A bit is stored only when its device-select value equals the latched strapped address. On a mismatch the bit is dropped, but the pointer advances exactly as it would after a real store.
- R6: When pointer + step reaches 80 or more, the pointer becomes pointer + step - 80 and the counter increments modulo 8. Bits whose column reaches 80 or more go to that column minus 80, and the match rule uses the incremented counter value.
- R7: A device-select command loads the counter from `dev_sel_sub` and leaves the pointer unchanged.
- R8: `xfer_abort` marks the pointer not valid. While the pointer is not valid, data bytes write nothing and do not move the pointer.
- R9: `hw_sub` is latched on each pointer load. Later changes of the pins have no effect until the next load.
- R10: `wr_pulse` is high for one cycle, in the cycle after an accepted byte strobe, when that byte stored at least one bit (even a 0 bit).
- R11: `rd_data` shows the rows of column `rd_col` one cycle later, with bit r being row r. A column of 80 or more reads as 0.
- R12: An abort wins over a pointer load in the same cycle. A byte strobe in the same cycle as any command or abort is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_ld | input | 1 | Pointer load command strobe |
| ptr_ld_col | input | 7 | Column for the pointer load |
| dev_sel | input | 1 | Device-select command strobe |
| dev_sel_sub | input | 3 | Counter value for the device-select command |
| xfer_abort | input | 1 | Bus transfer ended early |
| byte_stb | input | 1 | Data byte strobe |
| byte_val | input | 8 | Data byte |
| drive_mode | input | 2 | Rows per column: 00=1, 01=2, 10=3, 11=4 |
| hw_sub | input | 3 | Strapped device address |
| rd_col | input | 7 | Readback column |
| rd_data | output | 4 | Row bits of the readback column (registered) |
| wr_pulse | output | 1 | Accepted byte stored at least one bit (registered) |

## Verification
A pointer overflow and the bit stores of one byte can happen in the same cycle. The bench provokes this by strapping the device to address 1, selecting counter value 0 and loading column 78, then sending a one-row byte. The first two bits must be dropped and the last six must land in columns 0 to 5 under the advanced counter. The readback must show this split, and a following byte must land at column 6 on this same device. A command that coincides with a byte strobe is also driven, and the byte must leave the memory untouched.

// File: rtl/segld_pkg.sv
package segld_pkg;

  typedef enum logic [1:0] {
    MODE_ROW1 = 2'b00,
    MODE_ROW2 = 2'b01,
    MODE_ROW3 = 2'b10,
    MODE_ROW4 = 2'b11
  } drive_mode_e;

  // columns consumed by one byte in the given mode
  function automatic logic [3:0] col_step(input logic [1:0] m);
    case (m)
      MODE_ROW1: col_step = 4'd8;
      MODE_ROW2: col_step = 4'd4;
      MODE_ROW3: col_step = 4'd3;
      default:   col_step = 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/segld_ptr.sv
module segld_ptr #(
  parameter int COLS  = 80,
  parameter int PTR_W = 7,
  parameter int SUB_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_stb,
  input  logic [PTR_W-1:0] ld_col,
  input  logic             sel_stb,
  input  logic [SUB_W-1:0] sel_sub,
  input  logic             abort,
  input  logic             accept,
  input  logic [3:0]       step,
  input  logic [SUB_W-1:0] hw_sub,
  output logic [PTR_W-1:0] ptr,
  output logic [SUB_W-1:0] sub,
  output logic             valid,
  output logic [SUB_W-1:0] hw_q
);
  localparam logic [PTR_W:0] COLS_X = (PTR_W+1)'(COLS);

  logic [PTR_W:0] sum;
  logic           wrap;
  logic           ld_ok;

  assign sum   = {1'b0, ptr} + (PTR_W+1)'(step);
  assign wrap  = sum >= COLS_X;
  assign ld_ok = {1'b0, ld_col} < COLS_X;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      sub   <= '0;
      valid <= 1'b0;
      hw_q  <= '0;
    end else begin
      if (abort) begin
        valid <= 1'b0;
      end else if (ld_stb) begin
        valid <= ld_ok;
        ptr   <= ld_ok ? ld_col : '0;
        hw_q  <= hw_sub;
      end else if (accept) begin
        ptr <= wrap ? PTR_W'(sum - COLS_X) : PTR_W'(sum);
        if (wrap) sub <= sub + 1'b1;
      end
      if (sel_stb) sub <= sel_sub;
    end
  end

  // R6: a valid pointer always names an existing column
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (rst)
    valid |-> ({1'b0, ptr} < COLS_X));

  // R6: overflow of the pointer advances the device-select counter
  a_r6_sub_wrap: assert property (@(posedge clk) disable iff (rst)
    (accept && wrap) |=> (sub == $past(sub) + 1'b1));

  // R8: without a load or an accepted byte the pointer does not move
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld_stb && !accept) |=> $stable(ptr));

  // R9: the strapped address is only taken at a pointer load
  a_r9_hw_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_stb |=> $stable(hw_q));

endmodule

// File: rtl/segld_scatter.sv
module segld_scatter #(
  parameter int COLS   = 80,
  parameter int PTR_W  = 7,
  parameter int SUB_W  = 3,
  parameter int ROW_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SUB_W-1:0]  hw_q,
  input  logic [BYTE_W-1:0] data,
  input  logic              go,
  output logic [BYTE_W-1:0] lane_en,
  output logic [BYTE_W-1:0] lane_bit,
  output logic [PTR_W-1:0]  lane_col [BYTE_W],
  output logic [ROW_W-1:0]  lane_row [BYTE_W]
);
  localparam logic [PTR_W:0] COLS_X = (PTR_W+1)'(COLS);

  for (genvar k = 0; k < BYTE_W; k++) begin : g_lane
    logic [3:0]       off;
    logic [ROW_W-1:0] row;
    logic [PTR_W:0]   c_raw;
    logic             spill;
    logic [SUB_W-1:0] sub_k;

    always_comb begin
      case (mode)
        2'd0:    begin off = 4'(k);     row = '0;           end
        2'd1:    begin off = 4'(k / 2); row = ROW_W'(k % 2); end
        2'd2:    begin off = 4'(k / 3); row = ROW_W'(k % 3); end
        default: begin off = 4'(k / 4); row = ROW_W'(k % 4); end
      endcase
    end

    assign c_raw       = {1'b0, ptr} + (PTR_W+1)'(off);
    assign spill       = c_raw >= COLS_X;
    assign sub_k       = spill ? sub + 1'b1 : sub;
    assign lane_col[k] = spill ? PTR_W'(c_raw - COLS_X) : PTR_W'(c_raw);
    assign lane_row[k] = row;
    assign lane_en[k]  = go && (sub_k == hw_q);
    assign lane_bit[k] = data[BYTE_W-1-k];
  end

endmodule

// File: rtl/segld_bitmem.sv
module segld_bitmem #(
  parameter int COLS   = 80,
  parameter int ROWS   = 4,
  parameter int PTR_W  = 7,
  parameter int ROW_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] lane_en,
  input  logic [BYTE_W-1:0] lane_bit,
  input  logic [PTR_W-1:0]  lane_col [BYTE_W],
  input  logic [ROW_W-1:0]  lane_row [BYTE_W],
  input  logic [PTR_W-1:0]  rd_col,
  output logic [ROWS-1:0]   rd_data
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(COLS - 1);

  logic [ROWS-1:0] cells [COLS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < COLS; c++) cells[c] <= '0;
    end else begin
      for (int l = 0; l < BYTE_W; l++)
        if (lane_en[l]) cells[lane_col[l]][lane_row[l]] <= lane_bit[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_col <= LAST) ? cells[rd_col] : '0;
  end

  // R11: columns past the end read as zero
  a_r11_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_col > LAST) |=> (rd_data == '0));

endmodule

// File: rtl/seg_ram_loader.sv
module seg_ram_loader #(
  parameter int COLS   = 80,
  parameter int ROWS   = 4,
  parameter int PTR_W  = 7,
  parameter int SUB_W  = 3,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_ld,
  input  logic [PTR_W-1:0]  ptr_ld_col,
  input  logic              dev_sel,
  input  logic [SUB_W-1:0]  dev_sel_sub,
  input  logic              xfer_abort,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic [1:0]        drive_mode,
  input  logic [SUB_W-1:0]  hw_sub,
  input  logic [PTR_W-1:0]  rd_col,
  output logic [ROWS-1:0]   rd_data,
  output logic              wr_pulse
);
  import segld_pkg::*;

  localparam int ROW_W = $clog2(ROWS);

  logic [PTR_W-1:0]  ptr;
  logic [SUB_W-1:0]  sub;
  logic [SUB_W-1:0]  hw_q;
  logic              valid;
  logic              cmd_any;
  logic              accept;
  logic [BYTE_W-1:0] lane_en;
  logic [BYTE_W-1:0] lane_bit;
  logic [PTR_W-1:0]  lane_col [BYTE_W];
  logic [ROW_W-1:0]  lane_row [BYTE_W];

  assign cmd_any = ptr_ld | dev_sel | xfer_abort;
  assign accept  = byte_stb & valid & ~cmd_any;

  segld_ptr #(.COLS(COLS), .PTR_W(PTR_W), .SUB_W(SUB_W)) u_ptr (
    .clk(clk), .rst(rst),
    .ld_stb(ptr_ld), .ld_col(ptr_ld_col),
    .sel_stb(dev_sel), .sel_sub(dev_sel_sub),
    .abort(xfer_abort), .accept(accept),
    .step(col_step(drive_mode)), .hw_sub(hw_sub),
    .ptr(ptr), .sub(sub), .valid(valid), .hw_q(hw_q)
  );

  segld_scatter #(.COLS(COLS), .PTR_W(PTR_W), .SUB_W(SUB_W),
                  .ROW_W(ROW_W), .BYTE_W(BYTE_W)) u_scatter (
    .mode(drive_mode), .ptr(ptr), .sub(sub), .hw_q(hw_q),
    .data(byte_val), .go(accept),
    .lane_en(lane_en), .lane_bit(lane_bit),
    .lane_col(lane_col), .lane_row(lane_row)
  );

  segld_bitmem #(.COLS(COLS), .ROWS(ROWS), .PTR_W(PTR_W),
                 .ROW_W(ROW_W), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .rst(rst),
    .lane_en(lane_en), .lane_bit(lane_bit),
    .lane_col(lane_col), .lane_row(lane_row),
    .rd_col(rd_col), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_pulse <= 1'b0;
    else     wr_pulse <= |lane_en;
  end

  // R10: a store pulse always follows an accepted byte strobe
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> $past(accept));

  // R12: a byte strobe that meets a command stores nothing
  a_r12_cmd_blocks: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && cmd_any) |=> !wr_pulse);

  // R8: no store pulse while the pointer is not valid
  a_r8_no_store_invalid: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !valid) |=> !wr_pulse);

endmodule

// File: tb/sim_seg_ram_loader.sv
module sim_seg_ram_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ptr_ld = 1'b0;
  logic [6:0] ptr_ld_col = '0;
  logic       dev_sel = 1'b0;
  logic [2:0] dev_sel_sub = '0;
  logic       xfer_abort = 1'b0;
  logic       byte_stb = 1'b0;
  logic [7:0] byte_val = '0;
  logic [1:0] drive_mode = '0;
  logic [2:0] hw_sub = '0;
  logic [6:0] rd_col = '0;
  logic [3:0] rd_data;
  logic       wr_pulse;

  seg_ram_loader u0 (
    .clk(clk), .rst(rst), .ptr_ld(ptr_ld), .ptr_ld_col(ptr_ld_col),
    .dev_sel(dev_sel), .dev_sel_sub(dev_sel_sub), .xfer_abort(xfer_abort),
    .byte_stb(byte_stb), .byte_val(byte_val), .drive_mode(drive_mode),
    .hw_sub(hw_sub), .rd_col(rd_col), .rd_data(rd_data), .wr_pulse(wr_pulse)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  // reference model built from the requirements
  logic [3:0] m_mem [80];
  int m_ptr, m_sub, m_hw;
  bit m_valid;

  function automatic bit m_byte(input logic [7:0] b, input int mode);
    int rows, step, c, s;
    bit any;
    rows = mode + 1;
    step = (rows == 3) ? 3 : 8 / rows;
    any = 1'b0;
    for (int k = 0; k < 8; k++) begin
      c = m_ptr + k / rows;
      s = m_sub;
      if (c >= 80) begin c = c - 80; s = (s + 1) % 8; end
      if (s == m_hw) begin
        m_mem[c][k % rows] = b[7-k];
        any = 1'b1;
      end
    end
    m_ptr = m_ptr + step;
    if (m_ptr >= 80) begin m_ptr = m_ptr - 80; m_sub = (m_sub + 1) % 8; end
    return any;
  endfunction

  function automatic void push(input bit is_rd, input logic [3:0] e, input string t);
    item_t it;
    it.due = cyc + 1; it.is_rd = is_rd; it.exp = e; it.tag = t;
    q.push_back(it);
  endfunction

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin : mon
    item_t it;
    logic [3:0] act;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      act = it.is_rd ? rd_data : {3'b000, wr_pulse};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s: got %h expected %h", it.tag,
                 it.is_rd ? "rd_data" : "wr_pulse", act, it.exp);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 80; c++) m_mem[c] = '0;
    m_ptr = 0; m_sub = 0; m_hw = 0; m_valid = 1'b0;
  endtask

  task automatic load_ptr(input int col);
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_col = 7'(col);
    m_valid = (col < 80);
    if (m_valid) m_ptr = col;
    m_hw = int'(hw_sub);
    @(negedge clk);
    ptr_ld = 1'b0;
  endtask

  task automatic dev_select(input int s);
    @(negedge clk);
    dev_sel = 1'b1; dev_sel_sub = 3'(s);
    m_sub = s;
    @(negedge clk);
    dev_sel = 1'b0;
  endtask

  task automatic abort_x();
    @(negedge clk);
    xfer_abort = 1'b1;
    m_valid = 1'b0;
    @(negedge clk);
    xfer_abort = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string t);
    bit e;
    @(negedge clk);
    byte_stb = 1'b1; byte_val = b;
    e = m_valid ? m_byte(b, int'(drive_mode)) : 1'b0;
    push(1'b0, {3'b000, e}, t);
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic rb_exp(input int col, input logic [3:0] e, input string t);
    @(negedge clk);
    rd_col = 7'(col);
    push(1'b1, e, t);
    @(negedge clk);
  endtask

  task automatic rb_model(input int col, input string t);
    rb_exp(col, (col < 80) ? m_mem[col] : 4'h0, t);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] lfsr;
    do_reset();
    // R1 reset state
    push(1'b0, 4'h0, "R1");
    rb_exp(0, 4'h0, "R1");
    rb_exp(79, 4'h0, "R1");

    // R2 R3 R4 R10: one row per column
    hw_sub = 3'd0;
    dev_select(0);
    load_ptr(0);
    drive_mode = 2'b00;
    send_byte(8'hA5, "R10");
    rb_exp(0, 4'h1, "R4");
    rb_exp(2, 4'h1, "R4");
    rb_exp(3, 4'h0, "R4");
    send_byte(8'hFF, "R3");
    rb_exp(8, 4'h1, "R3");
    rb_exp(15, 4'h1, "R3");
    rb_exp(16, 4'h0, "R3");

    // R3 R4: four rows per column
    drive_mode = 2'b11;
    load_ptr(20);
    send_byte(8'b1100_0011, "R10");
    rb_exp(20, 4'b0011, "R4");
    rb_exp(21, 4'b1100, "R4");
    send_byte(8'hFF, "R3");
    rb_exp(22, 4'hF, "R3");
    rb_exp(23, 4'hF, "R3");

    // R4: three rows, row 2 of third column untouched
    load_ptr(30);
    send_byte(8'hFF, "R10");
    drive_mode = 2'b10;
    load_ptr(29);
    send_byte(8'b1011_0110, "R10");
    rb_exp(29, 4'b0101, "R4");
    rb_exp(30, 4'b1101, "R4");
    rb_exp(31, 4'b1101, "R4");
    send_byte(8'b1110_0000, "R3");
    rb_exp(32, 4'b0111, "R3");

    // R3 R4: two rows per column
    drive_mode = 2'b01;
    load_ptr(40);
    send_byte(8'b1001_1100, "R10");
    rb_exp(40, 4'b0001, "R4");
    rb_exp(41, 4'b0010, "R4");
    rb_exp(42, 4'b0011, "R4");
    rb_exp(43, 4'b0000, "R4");
    send_byte(8'hFF, "R3");
    rb_exp(44, 4'b0011, "R3");

    // R5 R7: mismatch skipped but pointer advances; select keeps pointer
    drive_mode = 2'b00;
    dev_select(1);
    load_ptr(50);
    send_byte(8'hFF, "R5");
    rb_exp(50, 4'h0, "R5");
    rb_exp(57, 4'h0, "R5");
    dev_select(0);
    send_byte(8'b1000_0000, "R7");
    rb_exp(58, 4'h1, "R7");
    rb_exp(50, 4'h0, "R7");

    // R6: overflow inside one byte moves to the next device
    hw_sub = 3'd1;
    dev_select(0);
    load_ptr(78);
    send_byte(8'hFF, "R6");
    rb_exp(78, 4'h0, "R6");
    rb_exp(1, 4'h1, "R6");
    rb_exp(5, 4'h1, "R6");
    rb_exp(6, 4'h0, "R6");
    send_byte(8'b1000_0000, "R6");
    rb_exp(6, 4'h1, "R6");

    // R9: strap change after load is ignored (zeros still stored)
    hw_sub = 3'd0;
    send_byte(8'h00, "R9");
    rb_exp(14, 4'h0, "R9");
    rb_model(20, "R9");

    // R8: abort blocks writes
    abort_x();
    send_byte(8'h00, "R8");
    rb_exp(22, 4'hF, "R8");

    // R2 R11: out-of-range load, out-of-range read
    dev_select(0);
    load_ptr(100);
    send_byte(8'h00, "R2");
    rb_exp(22, 4'hF, "R2");
    rb_exp(100, 4'h0, "R11");

    // R12: byte with a load in the same cycle is ignored
    load_ptr(60);
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_col = 7'd61; byte_stb = 1'b1; byte_val = 8'hFF;
    m_ptr = 61; m_hw = int'(hw_sub); m_valid = 1'b1;
    push(1'b0, 4'h0, "R12");
    @(negedge clk);
    ptr_ld = 1'b0; byte_stb = 1'b0;
    send_byte(8'b1000_0000, "R12");
    rb_exp(60, 4'h0, "R12");
    rb_exp(61, 4'h1, "R12");
    // R12: abort wins over a load
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_col = 7'd70; xfer_abort = 1'b1;
    m_valid = 1'b0;
    @(negedge clk);
    ptr_ld = 1'b0; xfer_abort = 1'b0;
    send_byte(8'hFF, "R12");
    rb_exp(70, 4'h0, "R12");

    // R4 R5 R6 scoreboard sweep over all modes and subaddresses
    hw_sub = 3'd2;
    dev_select(1);
    load_ptr(5);
    lfsr = 8'h5B;
    for (int i = 0; i < 120; i++) begin
      drive_mode = 2'(i % 4);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_byte(lfsr, "R5");
    end
    for (int c = 0; c < 80; c++) rb_model(c, "R6");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule